// File: doc/BRIEF.md
# Sampling-Delay Tuning Sequencer

This block picks a receive sampling delay for a high-speed (HS200) eMMC link without software in the loop. After a start pulse it tries every delay code from 0 up to a fixed last code, one at a time. For each code it puts the code on its tune output and holds an update request until the PHY side acknowledges. It then asks the link logic to run one tuning-block transfer and waits for a pass/fail answer.

While it sweeps, the block keeps the length of the current run of passing codes and the longest run seen so far, together with the code where that run ended. At the end it programs the centre of the longest run through the same update handshake. It then raises done. If no code passed, it raises error and leaves the delay unprogrammed. If the link is not running HS200 timing, it raises a not-applicable flag and does nothing else.

Both waits are bounded by cycle-count timeouts. A code whose update is never acknowledged counts as a failed step, and so does a transfer that never answers.

Top module: `tune_sweep_ctrl`

## Requirements
- R1: After reset, done, error, not-applicable, the update request and the test request are all low, and the tune output is 0.
- R2: A start while hs200_mode is low sets not_appl. No update request and no test request follow.
- R3: During a sweep, codes 0 to LAST_CODE (default 39) are presented in ascending order. Each code is offered once through the update request, and while the test request is high the tune output holds the code last offered.
- R4: If upd_ack does not arrive within UPD_TIMEOUT cycles, the step fails and no test request is issued for that code.
- R5: A step fails on a test result of fail, and also when no test_valid arrives within TEST_TIMEOUT cycles. A failed step restarts the current run at zero.
- R6: The best run changes only when the current run becomes strictly longer than it. Of two runs of equal length, the earlier one is kept.
- R7: The final code equals the last code of the best run minus half the run length, rounded down.
- R8: If no step passes, error is raised, done stays low and no final update is issued.
- R9: The final code is applied through the update handshake, and done rises only after its acknowledge.
- R10: If the final update times out, error is raised and done stays low.
- R11: The update request and the test request are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a search |
| hs200_mode | input | 1 | High when the link runs HS200 timing |
| tune_val | output | TUNE_W | Delay code presented to the PHY |
| upd_req | output | 1 | Request to apply tune_val; held until ack or timeout |
| upd_ack | input | 1 | One-cycle pulse: the code has taken effect |
| test_req | output | 1 | Request for one tuning-block transfer |
| test_valid | input | 1 | One-cycle pulse: transfer result is on test_pass |
| test_pass | input | 1 | Transfer result, 1 = pass |
| done | output | 1 | Search finished and the centre code is applied |
| error | output | 1 | No passing code, or the final update timed out |
| not_appl | output | 1 | Start arrived without HS200 timing |

## Verification
The assertions assume that upd_ack and test_valid arrive as single-cycle pulses, and only while the matching request is high. They also assume that start is not pulsed while a search is in progress. The bench responder answers only a request it currently sees, and clears each pulse on the falling edge that follows. Scenario tasks pulse start only once the previous run has settled. Timeouts are reached by having the responder hold back its answer for chosen codes.

// File: rtl/tune_sweep_ctrl.sv
module tune_sweep_ctrl #(
  parameter int TUNE_W       = 6,
  parameter int LAST_CODE    = 39,
  parameter int UPD_TIMEOUT  = 50,
  parameter int TEST_TIMEOUT = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              hs200_mode,
  output logic [TUNE_W-1:0] tune_val,
  output logic              upd_req,
  input  logic              upd_ack,
  output logic              test_req,
  input  logic              test_valid,
  input  logic              test_pass,
  output logic              done,
  output logic              error,
  output logic              not_appl
);
  localparam int RUN_W = $clog2(LAST_CODE + 2);
  localparam int TO_MAX = (UPD_TIMEOUT > TEST_TIMEOUT) ? UPD_TIMEOUT : TEST_TIMEOUT;
  localparam int CNT_W = $clog2(TO_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_UPD, S_TEST, S_NEXT, S_FIN} state_t;

  state_t            state;
  logic [TUNE_W-1:0] tune_q, best_end;
  logic [RUN_W-1:0]  cur_run, best_run, cur_next;
  logic [CNT_W-1:0]  cnt;
  logic              step_go, step_pass, upd_expired;

  assign tune_val    = tune_q;
  assign upd_req     = (state == S_UPD) || (state == S_FIN);
  assign test_req    = (state == S_TEST);
  assign upd_expired = !upd_ack && (cnt == CNT_W'(UPD_TIMEOUT - 1));
  assign cur_next    = step_pass ? cur_run + 1'b1 : '0;

  always_comb begin
    step_go   = 1'b0;
    step_pass = 1'b0;
    if (state == S_UPD && upd_expired) begin
      step_go = 1'b1;
    end else if (state == S_TEST) begin
      if (test_valid) begin
        step_go   = 1'b1;
        step_pass = test_pass;
      end else if (cnt == CNT_W'(TEST_TIMEOUT - 1)) begin
        step_go = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      tune_q   <= '0;
      best_end <= '0;
      cur_run  <= '0;
      best_run <= '0;
      cnt      <= '0;
      done     <= 1'b0;
      error    <= 1'b0;
      not_appl <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          done     <= 1'b0;
          error    <= 1'b0;
          not_appl <= !hs200_mode;
          if (hs200_mode) begin
            tune_q   <= '0;
            cur_run  <= '0;
            best_run <= '0;
            best_end <= '0;
            cnt      <= '0;
            state    <= S_UPD;
          end
        end
        S_UPD: begin
          if (upd_ack) begin
            cnt   <= '0;
            state <= S_TEST;
          end else if (!step_go) begin
            cnt <= cnt + 1'b1;
          end
        end
        S_TEST: if (!step_go) cnt <= cnt + 1'b1;
        S_NEXT: begin
          cnt <= '0;
          if (tune_q == TUNE_W'(LAST_CODE)) begin
            if (best_run == '0) begin
              error <= 1'b1;
              state <= S_IDLE;
            end else begin
              tune_q <= best_end - TUNE_W'(best_run >> 1);
              state  <= S_FIN;
            end
          end else begin
            tune_q <= tune_q + 1'b1;
            state  <= S_UPD;
          end
        end
        S_FIN: begin
          if (upd_ack) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (upd_expired) begin
            error <= 1'b1;
            state <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
      if (step_go) begin
        cur_run <= cur_next;
        if (step_pass && cur_next > best_run) begin
          best_run <= cur_next;
          best_end <= tune_q;
        end
        state <= S_NEXT;
      end
    end
  end

  assert_req_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_req && test_req));
  assert_code_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (test_req && $past(upd_req || test_req)) |-> $stable(tune_val));
  assert_sweep_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    test_req |-> (tune_val <= TUNE_W'(LAST_CODE)));
  assert_done_error_apart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  assert_done_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(upd_ack && upd_req));
  assert_best_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_TEST) |-> (best_run <= RUN_W'(tune_q)));
  assert_na_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    not_appl |-> !(upd_req || test_req));
endmodule

// File: tb/tune_sweep_ctrl_tb.sv
module tune_sweep_ctrl_tb;
  localparam int LAST = 39;
  localparam int UTO  = 8;
  localparam int TTO  = 12;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, hs200_mode = 1'b0;
  logic [5:0] tune_val;
  logic upd_req, upd_ack, test_req, test_valid, test_pass, done, error, not_appl;

  always #10 clk = ~clk;

  tune_sweep_ctrl #(.TUNE_W(6), .LAST_CODE(LAST), .UPD_TIMEOUT(UTO), .TEST_TIMEOUT(TTO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .hs200_mode(hs200_mode),
    .tune_val(tune_val), .upd_req(upd_req), .upd_ack(upd_ack),
    .test_req(test_req), .test_valid(test_valid), .test_pass(test_pass),
    .done(done), .error(error), .not_appl(not_appl));

  int checks = 0, failures = 0;
  logic [63:0] pass_map, ack_drop, resp_drop, tested;
  logic drop_final;
  int upd_num, tests, ucnt, tcnt, order_err, stab_err;
  logic upd_prev, test_prev;
  logic [5:0] last_upd;

  initial begin
    upd_ack = 1'b0; test_valid = 1'b0; test_pass = 1'b0;
    pass_map = '0; ack_drop = '0; resp_drop = '0; drop_final = 1'b0;
  end

  task automatic clear_log();
    upd_num = 0; tests = 0; ucnt = 0; tcnt = 0; order_err = 0; stab_err = 0;
    upd_prev = 1'b0; test_prev = 1'b0; tested = '0; last_upd = '0;
  endtask

  always @(negedge clk) begin
    upd_ack    <= 1'b0;
    test_valid <= 1'b0;
    if (upd_req) begin
      if (!upd_prev) begin
        if (upd_num < LAST + 1 && tune_val != 6'(upd_num)) order_err++;
        upd_num++;
        ucnt = 0;
        last_upd = tune_val;
      end else ucnt++;
      if (ucnt == 2 && !((upd_num <= LAST + 1) ? ack_drop[tune_val] : drop_final))
        upd_ack <= 1'b1;
    end
    if (test_req) begin
      if (tune_val != last_upd) stab_err++;
      if (!test_prev) begin
        tests++;
        tested[tune_val] = 1'b1;
        tcnt = 0;
      end else tcnt++;
      if (tcnt == 1 && !resp_drop[tune_val]) begin
        test_valid <= 1'b1;
        test_pass  <= pass_map[tune_val];
      end
    end
    upd_prev  = upd_req;
    test_prev = test_req;
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic hs);
    @(negedge clk);
    clear_log();
    hs200_mode = hs;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!(done || error) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 5000) begin
      failures++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
    end
  endtask

  task automatic run_sweep(input string name, input logic [63:0] p, input logic [63:0] ad,
                           input logic [63:0] rd, input logic df);
    logic [63:0] eff, want_tested;
    int cur = 0, best = 0, bend = 0;
    pass_map = p; ack_drop = ad; resp_drop = rd; drop_final = df;
    eff = p & ~ad & ~rd;
    for (int i = 0; i <= LAST; i++) begin
      if (eff[i]) begin
        cur++;
        if (cur > best) begin best = cur; bend = i; end
      end else cur = 0;
    end
    want_tested = ((64'd1 << (LAST + 1)) - 1) & ~ad;
    pulse_start(1'b1);
    wait_end();
    $display("scenario %s", name);
    check("R3 ascending order", order_err, 0);
    check("R3 code held during test", stab_err, 0);
    check("R4 tested codes", tested, want_tested);
    check("R11 no overlap seen", (upd_req && test_req), 0);
    if (best == 0) begin
      check("R8 error", error, 1);
      check("R8 done low", done, 0);
      check("R8 no final update", upd_num, LAST + 1);
    end else if (df) begin
      check("R10 error", error, 1);
      check("R10 done low", done, 0);
    end else begin
      check("R9 done", done, 1);
      check("R9 final update issued", upd_num, LAST + 2);
      check("R7 centre code", tune_val, bend - best / 2);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    clear_log();
    repeat (3) @(negedge clk);
    check("R1 done", done, 0);
    check("R1 error", error, 0);
    check("R1 not_appl", not_appl, 0);
    check("R1 upd_req", upd_req, 0);
    check("R1 test_req", test_req, 0);
    check("R1 tune_val", tune_val, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    pulse_start(1'b0);
    repeat (20) @(negedge clk);
    check("R2 not_appl", not_appl, 1);
    check("R2 no update", upd_num, 0);
    check("R2 no test", tests, 0);
    check("R2 done low", done, 0);

    run_sweep("all pass R7", (64'd1 << 40) - 1, '0, '0, 1'b0);
    run_sweep("equal runs R6", (64'h1F << 5) | (64'h1F << 20), '0, '0, 1'b0);
    run_sweep("longer later R6", (64'h7 << 3) | (64'h3F << 30), '0, '0, 1'b0);
    run_sweep("update timeout R4 R5", 64'hFFFF << 10, 64'd1 << 15, '0, 1'b0);
    run_sweep("test timeout R5", 64'h3FF, '0, 64'd1 << 4, 1'b0);
    run_sweep("fail result R5", 64'h3FF & ~(64'd1 << 6), '0, '0, 1'b0);
    run_sweep("no pass R8", '0, '0, '0, 1'b0);
    run_sweep("final timeout R10", 64'hFF << 8, '0, '0, 1'b1);
    run_sweep("single at 0 R7", 64'd1, '0, '0, 1'b0);
    run_sweep("single at last R7", 64'd1 << LAST, '0, '0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: global limit actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule